// File: doc/BRIEF.md
# Zone Protection Permission Resolver

This block turns the result of a TLB match into the access rights that apply to the current access. It takes the 4-bit zone selector carried by the matched entry, a 32-bit zone protection word that packs one 2-bit code per zone, the privilege level of the access, and the entry's own write and execute enables. It returns effective read, write and execute rights. It also registers a one-cycle fault strobe when a store or an instruction fetch is not permitted.

Two build-time parameters set the configuration. `MMU_MODE` selects whether zones take part in the decision: a value of 1 means zones are disabled. `NUM_ZONES` is the highest zone number the build implements. A zone number above that limit is treated as if its code were 1. The rights are combinational from the inputs, so they can sit on the translation path. The fault is registered, so it arrives as a clean strobe one cycle after the access.

Top module: `zone_prot_resolver`

## Requirements
- R1: The code for zone n is taken from bits (31-2n) down to (30-2n) of `zpr_i`, so zone 0 uses bits 31:30 and zone 7 uses bits 17:16.
- R2: When `zone_sel_i` is strictly greater than `NUM_ZONES`, the code is taken as 1 whatever `zpr_i` holds. A zone number equal to `NUM_ZONES` still uses its register code.
- R3: With `MMU_MODE` equal to 1, the code is always taken as 1 for every zone.
- R4: With code 0 and `user_i`=1, read, write and execute are all denied.
- R5: With code 1 in either mode, or code 0 with `user_i`=0, write follows `entry_wr_i` and execute follows `entry_ex_i`.
- R6: Code 2 grants write and execute when `user_i`=0. With `user_i`=1 it behaves like code 1.
- R7: Code 3 grants write and execute regardless of the entry enables.
- R8: With `hit_i`=1 and no denial, read is granted. With `hit_i`=0, no right is granted.
- R9: A hit with `store_i`=1 and no write right, or with `fetch_i`=1 and no execute right, sets `fault_o` at the next clock edge for one cycle. In every other case `fault_o` is low after the edge.
- R10: While `rst_ni` is low, `fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | A TLB entry matched this access |
| user_i | input | 1 | 1 = user mode access, 0 = supervisor |
| zone_sel_i | input | 4 | Zone selector field of the matched entry |
| zpr_i | input | 32 | Zone protection word, 2 bits per zone, zone 0 at the top |
| entry_wr_i | input | 1 | Entry's own write enable |
| entry_ex_i | input | 1 | Entry's own execute enable |
| store_i | input | 1 | Access is a store |
| fetch_i | input | 1 | Access is an instruction fetch |
| rd_o | output | 1 | Effective read right |
| wr_o | output | 1 | Effective write right |
| ex_o | output | 1 | Effective execute right |
| fault_o | output | 1 | Registered protection fault strobe |

## Verification
The table places each of the four codes in different zone positions. Each code is tried against both privilege levels and against entry enables that conflict with the code. This separates a mis-indexed protection word from a wrong decode, and separates a user/supervisor swap from an ignored entry bit. Zone numbers equal to and above `NUM_ZONES` are driven with protection words that would deny, or grant everything, if they were read. This exposes an off-by-one in the range test. A second instance built with zones disabled is given the same kind of words. Directed steps cover reset, a miss, and a fault followed by a clean access, which shows the strobe lasts one cycle.

// File: rtl/zone_prot_pkg.sv
package zone_prot_pkg;
  typedef enum logic [1:0] {
    ZC_DENY_USER = 2'd0,
    ZC_ENTRY     = 2'd1,
    ZC_SUP_FULL  = 2'd2,
    ZC_FULL      = 2'd3
  } zcode_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;
endpackage

// File: rtl/zone_code_sel.sv
module zone_code_sel
  import zone_prot_pkg::*;
#(
  parameter int MMU_MODE  = 3,
  parameter int NUM_ZONES = 8,
  parameter int ZSEL_W    = 4,
  localparam int ZCNT     = 2 ** ZSEL_W,
  localparam int ZPR_W    = 2 * ZCNT
) (
  input  logic [ZSEL_W-1:0] zone_sel_i,
  input  logic [ZPR_W-1:0]  zpr_i,
  output zcode_e            code_o
);
  localparam logic [ZSEL_W:0] ZLIMIT = (ZSEL_W + 1)'(NUM_ZONES);

  if (MMU_MODE == 1) begin : g_no_zones
    logic unused_in;
    assign unused_in = ^{zone_sel_i, zpr_i};
    assign code_o    = ZC_ENTRY;
  end else begin : g_zones
    logic [1:0] code_arr [ZCNT];
    for (genvar z = 0; z < ZCNT; z++) begin : g_slice
      // zone 0 sits at the most significant pair
      assign code_arr[z] = zpr_i[ZPR_W-1-2*z -: 2];
    end
    logic out_of_range;
    assign out_of_range = {1'b0, zone_sel_i} > ZLIMIT;
    assign code_o = out_of_range ? ZC_ENTRY : zcode_e'(code_arr[zone_sel_i]);
  end
endmodule

// File: rtl/zone_perm_decode.sv
module zone_perm_decode
  import zone_prot_pkg::*;
(
  input  zcode_e code_i,
  input  logic   hit_i,
  input  logic   user_i,
  input  logic   entry_wr_i,
  input  logic   entry_ex_i,
  output perm_t  perm_o
);
  logic deny, wr_r, ex_r;

  always_comb begin
    deny = 1'b0;
    wr_r = entry_wr_i;
    ex_r = entry_ex_i;
    unique case (code_i)
      ZC_DENY_USER: deny = user_i;
      ZC_ENTRY:     ;
      ZC_SUP_FULL:  if (!user_i) begin
                      wr_r = 1'b1;
                      ex_r = 1'b1;
                    end
      ZC_FULL:      begin
                      wr_r = 1'b1;
                      ex_r = 1'b1;
                    end
    endcase
    perm_o.rd = hit_i & ~deny;
    perm_o.wr = hit_i & ~deny & wr_r;
    perm_o.ex = hit_i & ~deny & ex_r;
  end
endmodule

// File: rtl/zone_fault_reg.sv
module zone_fault_reg
  import zone_prot_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hit_i,
  input  logic  store_i,
  input  logic  fetch_i,
  input  perm_t perm_i,
  output logic  fault_o
);
  logic viol;
  assign viol = hit_i & ((store_i & ~perm_i.wr) | (fetch_i & ~perm_i.ex));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_o <= 1'b0;
    else         fault_o <= viol;
  end

  assert_store_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && store_i && !perm_i.wr) |=> fault_o);
  assert_fetch_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && fetch_i && !perm_i.ex) |=> fault_o);
  assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i || ((!store_i || perm_i.wr) && (!fetch_i || perm_i.ex))) |=> !fault_o);
endmodule

// File: rtl/zone_prot_resolver.sv
module zone_prot_resolver
  import zone_prot_pkg::*;
#(
  parameter int MMU_MODE  = 3,
  parameter int NUM_ZONES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hit_i,
  input  logic        user_i,
  input  logic [3:0]  zone_sel_i,
  input  logic [31:0] zpr_i,
  input  logic        entry_wr_i,
  input  logic        entry_ex_i,
  input  logic        store_i,
  input  logic        fetch_i,
  output logic        rd_o,
  output logic        wr_o,
  output logic        ex_o,
  output logic        fault_o
);
  zcode_e code;
  perm_t  perm;

  zone_code_sel #(
    .MMU_MODE  (MMU_MODE),
    .NUM_ZONES (NUM_ZONES),
    .ZSEL_W    (4)
  ) u_code_sel (
    .zone_sel_i (zone_sel_i),
    .zpr_i      (zpr_i),
    .code_o     (code)
  );

  zone_perm_decode u_decode (
    .code_i     (code),
    .hit_i      (hit_i),
    .user_i     (user_i),
    .entry_wr_i (entry_wr_i),
    .entry_ex_i (entry_ex_i),
    .perm_o     (perm)
  );

  zone_fault_reg u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_i),
    .store_i (store_i),
    .fetch_i (fetch_i),
    .perm_i  (perm),
    .fault_o (fault_o)
  );

  assign rd_o = perm.rd;
  assign wr_o = perm.wr;
  assign ex_o = perm.ex;

  assert_user_deny_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && user_i && code == ZC_DENY_USER) |-> (!rd_o && !wr_o && !ex_o));
  assert_full_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && code == ZC_FULL) |-> (rd_o && wr_o && ex_o));
  assert_sup_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !user_i && code == ZC_SUP_FULL) |-> (wr_o && ex_o));
  assert_miss_none_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |-> (!rd_o && !wr_o && !ex_o));
  assert_range_force_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(zone_sel_i) > NUM_ZONES) |-> (code == ZC_ENTRY));

  if (MMU_MODE == 1) begin : g_chk_nozone
    assert_nozone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code == ZC_ENTRY);
  end
endmodule

// File: tb/zone_prot_resolver_bench.sv
module zone_prot_resolver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic        hit, user, ewr, eex, st, fe;
  logic [3:0]  zone;
  logic [31:0] zpr;
  logic        rd, wr, ex, flt;
  logic        rd1, wr1, ex1, flt1;

  int n_chk = 0;
  int n_bad = 0;

  zone_prot_resolver #(.MMU_MODE(3), .NUM_ZONES(8)) u_zone_prot_resolver (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .user_i(user), .zone_sel_i(zone),
    .zpr_i(zpr), .entry_wr_i(ewr), .entry_ex_i(eex), .store_i(st), .fetch_i(fe),
    .rd_o(rd), .wr_o(wr), .ex_o(ex), .fault_o(flt));

  zone_prot_resolver #(.MMU_MODE(1), .NUM_ZONES(8)) u_nozone (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .user_i(user), .zone_sel_i(zone),
    .zpr_i(zpr), .entry_wr_i(ewr), .entry_ex_i(eex), .store_i(st), .fetch_i(fe),
    .rd_o(rd1), .wr_o(wr1), .ex_o(ex1), .fault_o(flt1));

  // {zpr, zone, user ewr eex st fe, exp rd wr ex fault}
  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {32'h0000_0000, 4'd0,  5'b1_11_10, 4'b0001}, // R4 code0 user
    {32'h0000_0000, 4'd0,  5'b0_10_01, 4'b1101}, // R5 code0 sup
    {32'h1000_0000, 4'd1,  5'b1_01_10, 4'b1011}, // R5 code1 user
    {32'h0800_0000, 4'd2,  5'b0_00_11, 4'b1110}, // R6 code2 sup
    {32'h0800_0000, 4'd2,  5'b1_00_01, 4'b1001}, // R6 code2 user
    {32'h0300_0000, 4'd3,  5'b1_00_11, 4'b1110}, // R7 code3
    {32'hFFFC_FFFF, 4'd7,  5'b1_11_00, 4'b0000}, // R1 zone7 code0
    {32'h0003_0000, 4'd7,  5'b1_00_00, 4'b1110}, // R1 zone7 code3
    {32'h0000_0000, 4'd8,  5'b1_11_00, 4'b0000}, // R2 zone==limit
    {32'h0000_0000, 4'd9,  5'b1_10_10, 4'b1100}, // R2 zone>limit
    {32'hFFFF_FFFF, 4'd15, 5'b1_00_01, 4'b1001}, // R2 zone15
    {32'h4000_0000, 4'd0,  5'b0_11_11, 4'b1110}  // R5 code1 sup
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] z, input logic [3:0] zs, input logic [4:0] m, input logic h);
    zpr = z; zone = zs; {user, ewr, eex, st, fe} = m; hit = h;
  endtask

  initial begin
    drive(32'h0, 4'd0, 5'b1_11_10, 1'b1);
    repeat (2) @(posedge clk);
    #1 chk("R10 reset", {3'b000, flt}, 4'b0000);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][44:13], VEC[i][12:9], VEC[i][8:4], 1'b1);
      #1 chk($sformatf("R1-table rights vec%0d", i), {rd, wr, ex, 1'b0}, {VEC[i][3:1], 1'b0});
      @(posedge clk);
      #1 chk($sformatf("R9 fault vec%0d", i), {3'b000, flt}, {3'b000, VEC[i][0]});
    end

    // R8: miss grants nothing, no fault
    @(negedge clk);
    drive(32'hFFFF_FFFF, 4'd0, 5'b0_11_11, 1'b0);
    #1 chk("R8 miss", {rd, wr, ex, 1'b0}, 4'b0000);
    @(posedge clk);
    #1 chk("R9 miss no fault", {3'b000, flt}, 4'b0000);

    // R9: strobe lasts one cycle
    @(negedge clk);
    drive(32'h0, 4'd0, 5'b1_11_01, 1'b1);
    @(posedge clk);
    #1 chk("R9 strobe set", {3'b000, flt}, 4'b0001);
    @(negedge clk);
    drive(32'h0, 4'd0, 5'b0_11_00, 1'b1);
    @(posedge clk);
    #1 chk("R9 strobe cleared", {3'b000, flt}, 4'b0000);

    // R3: zones disabled
    @(negedge clk);
    drive(32'h0000_0000, 4'd0, 5'b1_10_01, 1'b1);
    #1 chk("R3 nozone code0 ignored", {rd1, wr1, ex1, 1'b0}, 4'b1100);
    @(posedge clk);
    #1 chk("R3 nozone fault", {3'b000, flt1}, 4'b0001);
    @(negedge clk);
    drive(32'hFFFF_FFFF, 4'd3, 5'b1_00_00, 1'b1);
    #1 chk("R3 nozone code3 ignored", {rd1, wr1, ex1, 1'b0}, 4'b1000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule